// File: doc/BRIEF.md
# Cascadable Lookahead Arithmetic/Logic Unit

This block is a purely combinational arithmetic/logic core. It takes two operands, a three-bit function code and a carry-in, and returns a result word together with cascade status. There are eight functions: two constant loads, three additions, one of them with an inverted operand on either side, and three bitwise operations.

Carries are formed in lookahead form from per-bit generate and propagate terms. The group generate and group propagate of the whole word are exported active low. Several copies can therefore be joined through an external carry-lookahead unit, or chained directly through the carry-out. Overflow and a zero flag complete the status. Carry, overflow, generate and propagate are defined only for the arithmetic codes. For every other code they rest at fixed inactive levels.

Top module: `cascade_alu`

## Requirements
- R1: Function code 3'b000 drives the result to all zeros.
- R2: Function code 3'b111 drives the result to all ones.
- R3: Function code 3'b011 gives result = A + B + carry-in modulo 2^WIDTH, and the carry-out is bit WIDTH of that sum.
- R4: Function code 3'b001 adds the inverted A to B plus carry-in; with carry-in 1 the result equals B - A in two's complement.
- R5: Function code 3'b010 adds A to the inverted B plus carry-in; with carry-in 1 the result equals A - B in two's complement.
- R6: Function codes 3'b100, 3'b101 and 3'b110 give A XOR B, A OR B and A AND B respectively.
- R7: For arithmetic codes, the propagate output is low exactly when every bit of (effective A OR effective B) is 1. The generate output is low exactly when the effective operands added with carry-in 0 produce a carry-out. Effective operands are taken after any inversion.
- R8: For arithmetic codes, overflow is high exactly when the signed sum of the effective operands plus carry-in does not fit in WIDTH bits, that is, when the carry into the top bit differs from the carry-out.
- R9: The zero flag is high exactly when every result bit is 0, for every code.
- R10: For non-arithmetic codes, carry-out and overflow are 0, and the generate and propagate outputs are 1.
- R11: For arithmetic codes, the carry-out equals (NOT generate) OR ((NOT propagate) AND carry-in).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| funcSel | input | 3 | Function code |
| aIn | input | WIDTH | Operand A |
| bIn | input | WIDTH | Operand B |
| carryIn | input | 1 | Carry into bit 0 |
| fOut | output | WIDTH | Result |
| carryOut | output | 1 | Carry out of the top bit |
| genN | output | 1 | Group generate, active low |
| propN | output | 1 | Group propagate, active low |
| ovfOut | output | 1 | Two's-complement overflow |
| zeroOut | output | 1 | All result bits zero |

## Verification
The bench builds the block with its default WIDTH of 16. At that width the signed boundary values 0x7FFF and 0x8000, the all-ones word and the full sixteen-stage carry ripple are all reachable. Directed corner pairs are run under every function code with both carry-in values. Random operands follow, so that group propagate holds without group generate and the cascade relation between carry-in and carry-out is exercised.

// File: rtl/alu_pkg.sv
`timescale 1ns/1ps
package alu_pkg;
  typedef enum logic [2:0] {
    FN_CLEAR  = 3'b000,
    FN_NASUB  = 3'b001,
    FN_NBSUB  = 3'b010,
    FN_ADD    = 3'b011,
    FN_XOR    = 3'b100,
    FN_OR     = 3'b101,
    FN_AND    = 3'b110,
    FN_PRESET = 3'b111
  } aluFnE;

  typedef enum logic [1:0] {
    BIT_XOR = 2'd0,
    BIT_OR  = 2'd1,
    BIT_AND = 2'd2
  } bitOpE;

  typedef struct packed {
    logic  invA;
    logic  invB;
    logic  arithEn;
    logic  constEn;
    logic  constVal;
    bitOpE bitOp;
  } aluStrobeT;
endpackage

// File: rtl/alu_ctrl.sv
`timescale 1ns/1ps
module alu_ctrl
  import alu_pkg::*;
(
  input  logic [2:0] funcSel,
  output aluStrobeT  strobe
);
  always_comb begin
    strobe = '{invA: 1'b0, invB: 1'b0, arithEn: 1'b0, constEn: 1'b0,
               constVal: 1'b0, bitOp: BIT_XOR};
    unique case (aluFnE'(funcSel))
      FN_CLEAR:  strobe.constEn = 1'b1;
      FN_PRESET: begin strobe.constEn = 1'b1; strobe.constVal = 1'b1; end
      FN_NASUB:  begin strobe.arithEn = 1'b1; strobe.invA = 1'b1; end
      FN_NBSUB:  begin strobe.arithEn = 1'b1; strobe.invB = 1'b1; end
      FN_ADD:    strobe.arithEn = 1'b1;
      FN_XOR:    strobe.bitOp = BIT_XOR;
      FN_OR:     strobe.bitOp = BIT_OR;
      FN_AND:    strobe.bitOp = BIT_AND;
      default:   strobe.constEn = 1'b1;
    endcase
  end
endmodule

// File: rtl/alu_datapath.sv
`timescale 1ns/1ps
module alu_datapath
  import alu_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  aluStrobeT        strobe,
  input  logic [WIDTH-1:0] aIn,
  input  logic [WIDTH-1:0] bIn,
  input  logic             carryIn,
  output logic [WIDTH-1:0] fOut,
  output logic             carryOut,
  output logic             genN,
  output logic             propN,
  output logic             ovfOut,
  output logic             zeroOut
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] effA, effB, bitGen, bitProp;
  logic [WIDTH-1:0] grpGen, grpProp, sumBits, bitRes;
  logic [WIDTH:0]   carry;

  assign effA = strobe.invA ? ~aIn : aIn;
  assign effB = strobe.invB ? ~bIn : bIn;

  // per-bit terms, one cell per bit position
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign bitGen[i]  = effA[i] & effB[i];
    assign bitProp[i] = effA[i] | effB[i];
  end

  // prefix generate/propagate; each carry derives from carry-in directly
  always_comb begin
    grpGen[0]  = bitGen[0];
    grpProp[0] = bitProp[0];
    for (int i = 1; i < WIDTH; i++) begin
      grpGen[i]  = bitGen[i] | (bitProp[i] & grpGen[i-1]);
      grpProp[i] = bitProp[i] & grpProp[i-1];
    end
    carry[0] = carryIn;
    for (int i = 0; i < WIDTH; i++)
      carry[i+1] = grpGen[i] | (grpProp[i] & carryIn);
  end

  assign sumBits = effA ^ effB ^ carry[MSB:0];

  always_comb begin
    unique case (strobe.bitOp)
      BIT_OR:  bitRes = aIn | bIn;
      BIT_AND: bitRes = aIn & bIn;
      default: bitRes = aIn ^ bIn;
    endcase
  end

  always_comb begin
    if (strobe.constEn)      fOut = {WIDTH{strobe.constVal}};
    else if (strobe.arithEn) fOut = sumBits;
    else                     fOut = bitRes;
  end

  assign carryOut = strobe.arithEn & carry[WIDTH];
  assign ovfOut   = strobe.arithEn & (carry[WIDTH] ^ carry[MSB]);
  assign genN     = ~(strobe.arithEn & grpGen[MSB]);
  assign propN    = ~(strobe.arithEn & grpProp[MSB]);
  assign zeroOut  = ~|fOut;

  // R7: a full group propagate with carry-in set must yield the sum's carry
  always_comb begin
    if (strobe.arithEn && grpProp[MSB] && carryIn)
      assert_prop_carry_R7: assert (carry[WIDTH] && fOut == (effA + effB + 1'b1));
  end
endmodule

// File: rtl/cascade_alu.sv
`timescale 1ns/1ps
module cascade_alu
  import alu_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic [2:0]       funcSel,
  input  logic [WIDTH-1:0] aIn,
  input  logic [WIDTH-1:0] bIn,
  input  logic             carryIn,
  output logic [WIDTH-1:0] fOut,
  output logic             carryOut,
  output logic             genN,
  output logic             propN,
  output logic             ovfOut,
  output logic             zeroOut
);
  aluStrobeT strobe;

  alu_ctrl u_ctrl (.funcSel(funcSel), .strobe(strobe));

  alu_datapath #(.WIDTH(WIDTH)) u_dp (
    .strobe(strobe), .aIn(aIn), .bIn(bIn), .carryIn(carryIn),
    .fOut(fOut), .carryOut(carryOut), .genN(genN), .propN(propN),
    .ovfOut(ovfOut), .zeroOut(zeroOut)
  );

  logic isArith;
  assign isArith = (funcSel == 3'b001) || (funcSel == 3'b010) || (funcSel == 3'b011);

  always_comb begin
    if (funcSel == 3'b000)
      assert_clear_R1: assert (fOut == '0 && zeroOut);
    if (funcSel == 3'b111)
      assert_preset_R2: assert (fOut == '1 && !zeroOut);
    if (!isArith)
      assert_quiet_flags_R10: assert (!carryOut && !ovfOut && genN && propN);
    if (isArith)
      assert_cascade_R11: assert (carryOut == (!genN || (!propN && carryIn)));
  end
endmodule

// File: tb/cascade_alu_tb_top.sv
`timescale 1ns/1ps
module cascade_alu_tb_top;
  localparam int W = 16;
  localparam int MAX_CYCLES = 20000;

  typedef struct {
    logic [W-1:0] f;
    logic         c16, gN, pN, ovf, zero, arith;
    string        tag;
  } expT;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic [2:0]   funcSel = 3'b000;
  logic [W-1:0] aIn = '0, bIn = '0;
  logic         carryIn = 1'b0;
  logic [W-1:0] fOut;
  logic         carryOut, genN, propN, ovfOut, zeroOut;

  cascade_alu #(.WIDTH(W)) dut_i (
    .funcSel(funcSel), .aIn(aIn), .bIn(bIn), .carryIn(carryIn),
    .fOut(fOut), .carryOut(carryOut), .genN(genN), .propN(propN),
    .ovfOut(ovfOut), .zeroOut(zeroOut)
  );

  int checks = 0;
  int failures = 0;
  bit finished = 0;
  expT sbQ[$];

  function automatic expT model(logic [2:0] s, logic [W-1:0] a, logic [W-1:0] b, logic ci);
    expT e;
    logic [W-1:0] ea, eb;
    logic [W:0] sum, sum0;
    ea = (s == 3'b001) ? ~a : a;
    eb = (s == 3'b010) ? ~b : b;
    sum  = {1'b0, ea} + {1'b0, eb} + {{W{1'b0}}, ci};
    sum0 = {1'b0, ea} + {1'b0, eb};
    e.arith = (s == 3'b001) || (s == 3'b010) || (s == 3'b011);
    e.c16 = 1'b0; e.ovf = 1'b0; e.gN = 1'b1; e.pN = 1'b1;
    case (s)
      3'b000: begin e.f = '0;     e.tag = "R1"; end
      3'b111: begin e.f = '1;     e.tag = "R2"; end
      3'b011: begin e.f = sum[W-1:0]; e.tag = "R3"; end
      3'b001: begin e.f = sum[W-1:0]; e.tag = "R4"; end
      3'b010: begin e.f = sum[W-1:0]; e.tag = "R5"; end
      3'b100: begin e.f = a ^ b;  e.tag = "R6"; end
      3'b101: begin e.f = a | b;  e.tag = "R6"; end
      default: begin e.f = a & b; e.tag = "R6"; end
    endcase
    if (e.arith) begin
      e.c16 = sum[W];
      e.gN  = ~sum0[W];
      e.pN  = ~(&(ea | eb));
      e.ovf = (ea[W-1] == eb[W-1]) && (sum[W-1] != ea[W-1]);
    end
    e.zero = (e.f == '0);
    return e;
  endfunction

  task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h (sel=%b a=%h b=%h cin=%b)",
               req, act, exp, funcSel, aIn, bIn, carryIn);
    end
  endtask

  // driver: applies a vector after the rising edge, queues its expectation
  task automatic drive(logic [2:0] s, logic [W-1:0] a, logic [W-1:0] b, logic ci, string tagOvr = "");
    expT e;
    @(posedge clk);
    #1;
    funcSel = s; aIn = a; bIn = b; carryIn = ci;
    e = model(s, a, b, ci);
    if (tagOvr != "") e.tag = tagOvr;
    sbQ.push_back(e);
  endtask

  // monitor: compares on the falling edge
  initial begin
    forever begin
      @(negedge clk);
      if (sbQ.size() > 0) begin
        expT e;
        e = sbQ.pop_front();
        check(e.tag, fOut, e.f);
        check("R9", {{(W-1){1'b0}}, zeroOut}, {{(W-1){1'b0}}, e.zero});
        if (e.arith) begin
          check("R11", {{(W-1){1'b0}}, carryOut}, {{(W-1){1'b0}}, e.c16});
          check("R8",  {{(W-1){1'b0}}, ovfOut},   {{(W-1){1'b0}}, e.ovf});
          check("R7",  {{(W-2){1'b0}}, genN, propN}, {{(W-2){1'b0}}, e.gN, e.pN});
        end else begin
          check("R10", {{(W-4){1'b0}}, carryOut, ovfOut, genN, propN},
                       {{(W-4){1'b0}}, 1'b0, 1'b0, 1'b1, 1'b1});
        end
      end
    end
  end

  initial begin
    logic [W-1:0] corners [5];
    corners[0] = 16'h0000; corners[1] = 16'hFFFF; corners[2] = 16'h7FFF;
    corners[3] = 16'h8000; corners[4] = 16'h0001;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    // reset-time idle state: code 000 with zero operands
    @(negedge clk);
    check("R1", fOut, '0);
    check("R9", {{(W-1){1'b0}}, zeroOut}, {{(W-1){1'b0}}, 1'b1});
    // explicit subtraction forms
    drive(3'b001, 16'd5, 16'd12, 1'b1, "R4");
    drive(3'b010, 16'd12, 16'd5, 1'b1, "R5");
    drive(3'b010, 16'h8000, 16'h0001, 1'b1, "R8");
    drive(3'b011, 16'hFFFF, 16'h0001, 1'b0, "R3");
    // propagate-only carry: group propagate without generate
    drive(3'b011, 16'hF0F0, 16'h0F0F, 1'b1, "R11");
    drive(3'b011, 16'hF0F0, 16'h0F0F, 1'b0, "R11");
    for (int s = 0; s < 8; s++)
      for (int i = 0; i < 5; i++)
        for (int j = 0; j < 5; j++)
          for (int c = 0; c < 2; c++)
            drive(3'(s), corners[i], corners[j], 1'(c));
    for (int n = 0; n < 400; n++)
      drive(3'($urandom_range(7)), W'($urandom), W'($urandom), 1'($urandom_range(1)));
    while (sbQ.size() > 0) @(posedge clk);
    @(posedge clk);
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (MAX_CYCLES) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule